// File: doc/BRIEF.md
# Operand-Location Cluster Steering Unit

This block sits in front of register renaming on a four-cluster machine. Each cluster writes its results only into its own subset of the physical registers, and it reads each operand from only two of the four subsets. Because of this, the cluster that runs an instruction is set by where its source operands live now. The cluster is not picked to balance load. The unit keeps a two-bit location (the subset number) for every logical register, held as two bit vectors. For each instruction in a rename group it works out a 2-bit cluster number, and it then records that cluster as the new location of the instruction's destination.

The cluster number is built from two independent bits. The high bit comes from the subset of the first source operand, which chooses the upper or lower cluster pair. The low bit comes from the subset of the second source operand, which chooses the left or right pair. A source written by an older instruction of the same group is located at that older instruction's chosen cluster rather than at the stored value. When an instruction gives a free choice, a per-slot random input settles it: an instruction with one operand or none, or a commutative instruction whose operands may be swapped.

A small state machine has two states. `ST_IDLE` means no result is presented. `ST_EMIT` means the results of the group accepted on the previous edge are on the outputs. The accept transition (`grp_valid` high at a clock edge) enters `ST_EMIT` from either state. The drain transition (`grp_valid` low) returns to `ST_IDLE`.

Top module: `steer_unit`

## Requirements
- R1: After reset, `out_valid` is 0. Logical register r is located in subset r mod 4: its high location bit is bit 1 of r and its low location bit is bit 0 of r.
- R2: A group is accepted on a clock edge where `grp_valid` is 1. Its results appear with `out_valid` = 1 for the following cycle only. While `out_valid` is 0, `out_cluster` and `out_swap` are all zero.
- R3: For a dyadic slot (operand count field 2, and 3 is treated the same) with no swap, the cluster is {high bit of src1's location, low bit of src2's location}.
- R4: For a monadic slot (operand count 1), the cluster is {high bit of src1's location, bit 0 of the slot's random field}.
- R5: For a slot with no register operands (operand count 0), the cluster equals the slot's 2-bit random field.
- R6: A dyadic slot swaps its operands when three things hold: its commutative flag is 1, the two source locations differ, and bit 0 of its random field is 1. The cluster is then {high bit of src2's location, low bit of src1's location} and its `out_swap` bit is 1. In all other cases `out_swap` is 0.
- R7: A source that matches the destination of an older valid slot in the same group with `dst_en` = 1 takes its location from the youngest such older slot's cluster, not from the stored map.
- R8: After an accepted group, every destination written in it is located at the cluster of the youngest valid slot that wrote it. Later groups see that location, including a group accepted on the very next edge.
- R9: An invalid slot (its `slot_valid` bit is 0) reports cluster 0 and swap 0. It neither forwards to younger slots nor updates the map.
- R10: Slot inputs presented while `grp_valid` is 0 leave the location map unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | Accept the presented group on this edge |
| slot_valid | input | NSLOT | Per-slot instruction present (bit i = slot i, slot 0 oldest) |
| src1 | input | NSLOT*LW | First source logical register per slot |
| src2 | input | NSLOT*LW | Second source logical register per slot |
| dst | input | NSLOT*LW | Destination logical register per slot |
| dst_en | input | NSLOT | Slot writes its destination |
| nops | input | 2*NSLOT | Register operand count per slot (0, 1, 2; 3 acts as 2) |
| comm | input | NSLOT | Slot's operation is commutative |
| rnd | input | 2*NSLOT | Per-slot random bits |
| out_valid | output | 1 | Results of the previously accepted group are valid |
| out_cluster | output | 2*NSLOT | Chosen cluster per slot |
| out_swap | output | NSLOT | Operands of the slot were exchanged |

## Verification
The hardest case to reach is a source resolved through several older writers of one group. The location must come from a chain of forwarded clusters, where each one may itself have come from forwarding or from a random bit. The bench builds such chains on purpose: a no-operand writer feeds a dyadic writer of the same register, which feeds a monadic slot and then a dyadic slot. Other cases cover a register written twice before it is read and an invalid slot that names a matching destination. A following group then reads those registers on the very next edge, and randomized groups with small register numbers make such collisions common.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } steer_state_t;

    typedef struct packed {
        logic [1:0] cl;
        logic       swp;
    } pick_t;

    // Cluster choice for one slot from its resolved operand locations.
    function automatic pick_t steer_choose(
        input logic [1:0] n_ops,
        input logic       is_comm,
        input logic [1:0] rbits,
        input logic [1:0] loc_a,
        input logic [1:0] loc_b
    );
        pick_t p;
        p.swp = 1'b0;
        unique case (n_ops)
            2'd0:    p.cl = rbits;
            2'd1:    p.cl = {loc_a[1], rbits[0]};
            default: begin
                if (is_comm && (loc_a != loc_b) && rbits[0]) begin
                    p.cl  = {loc_b[1], loc_a[0]};
                    p.swp = 1'b1;
                end else begin
                    p.cl = {loc_a[1], loc_b[0]};
                end
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/steer_locmap.sv
module steer_locmap #(
    parameter int NLREG = 32,
    parameter int NSLOT = 4,
    parameter int LW    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [NSLOT-1:0]      upd_en,
    input  logic [NSLOT*LW-1:0]   upd_dst,
    input  logic [2*NSLOT-1:0]    upd_cl,
    output logic [NLREG-1:0]      map_hi,
    output logic [NLREG-1:0]      map_lo
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NLREG; r++) begin
                map_hi[r] <= ((r % 4) >= 2);
                map_lo[r] <= ((r % 2) == 1);
            end
        end else if (wr_en) begin
            // Oldest to youngest: the youngest writer's value lands last.
            for (int s = 0; s < NSLOT; s++) begin
                if (upd_en[s]) begin
                    map_hi[upd_dst[s*LW +: LW]] <= upd_cl[2*s+1];
                    map_lo[upd_dst[s*LW +: LW]] <= upd_cl[2*s];
                end
            end
        end
    end

    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(map_hi) && $stable(map_lo))); // R10

    AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && upd_en[NSLOT-1]) |=>
        ({map_hi[$past(upd_dst[(NSLOT-1)*LW +: LW])],
          map_lo[$past(upd_dst[(NSLOT-1)*LW +: LW])]}
         == $past(upd_cl[2*NSLOT-1 -: 2]))); // R8

endmodule

// File: rtl/steer_fwd.sv
module steer_fwd
    import steer_pkg::*;
#(
    parameter int NLREG = 32,
    parameter int NSLOT = 4,
    parameter int LW    = 5
) (
    input  logic [NLREG-1:0]      map_hi,
    input  logic [NLREG-1:0]      map_lo,
    input  logic [NSLOT-1:0]      slot_valid,
    input  logic [NSLOT*LW-1:0]   src1,
    input  logic [NSLOT*LW-1:0]   src2,
    input  logic [NSLOT*LW-1:0]   dst,
    input  logic [NSLOT-1:0]      dst_en,
    input  logic [2*NSLOT-1:0]    nops,
    input  logic [NSLOT-1:0]      comm,
    input  logic [2*NSLOT-1:0]    rnd,
    output logic [2*NSLOT-1:0]    cl,
    output logic [NSLOT-1:0]      swp
);

    always_comb begin
        logic [1:0]    loc_a;
        logic [1:0]    loc_b;
        logic [LW-1:0] ra;
        logic [LW-1:0] rb;
        pick_t         p;
        cl  = '0;
        swp = '0;
        for (int i = 0; i < NSLOT; i++) begin
            ra    = src1[i*LW +: LW];
            rb    = src2[i*LW +: LW];
            loc_a = {map_hi[ra], map_lo[ra]};
            loc_b = {map_hi[rb], map_lo[rb]};
            // Older slots in ascending order: the youngest match wins.
            for (int j = 0; j < i; j++) begin
                if (slot_valid[j] && dst_en[j]) begin
                    if (dst[j*LW +: LW] == ra) loc_a = cl[2*j +: 2];
                    if (dst[j*LW +: LW] == rb) loc_b = cl[2*j +: 2];
                end
            end
            p = steer_choose(nops[2*i +: 2], comm[i], rnd[2*i +: 2], loc_a, loc_b);
            if (slot_valid[i]) begin
                cl[2*i +: 2] = p.cl;
                swp[i]       = p.swp;
            end
        end
    end

endmodule

// File: rtl/steer_unit.sv
module steer_unit
    import steer_pkg::*;
#(
    parameter int NLREG = 32,
    parameter int NSLOT = 4,
    localparam int LW   = $clog2(NLREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  grp_valid,
    input  logic [NSLOT-1:0]      slot_valid,
    input  logic [NSLOT*LW-1:0]   src1,
    input  logic [NSLOT*LW-1:0]   src2,
    input  logic [NSLOT*LW-1:0]   dst,
    input  logic [NSLOT-1:0]      dst_en,
    input  logic [2*NSLOT-1:0]    nops,
    input  logic [NSLOT-1:0]      comm,
    input  logic [2*NSLOT-1:0]    rnd,
    output logic                  out_valid,
    output logic [2*NSLOT-1:0]    out_cluster,
    output logic [NSLOT-1:0]      out_swap
);

    steer_state_t         state_q;
    steer_state_t         state_d;
    logic [NLREG-1:0]     map_hi;
    logic [NLREG-1:0]     map_lo;
    logic [2*NSLOT-1:0]   cl_now;
    logic [NSLOT-1:0]     swp_now;
    logic [2*NSLOT-1:0]   cl_q;
    logic [NSLOT-1:0]     swp_q;

    steer_fwd #(.NLREG(NLREG), .NSLOT(NSLOT), .LW(LW)) u_fwd (
        .map_hi     (map_hi),
        .map_lo     (map_lo),
        .slot_valid (slot_valid),
        .src1       (src1),
        .src2       (src2),
        .dst        (dst),
        .dst_en     (dst_en),
        .nops       (nops),
        .comm       (comm),
        .rnd        (rnd),
        .cl         (cl_now),
        .swp        (swp_now)
    );

    steer_locmap #(.NLREG(NLREG), .NSLOT(NSLOT), .LW(LW)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (grp_valid),
        .upd_en  (slot_valid & dst_en),
        .upd_dst (dst),
        .upd_cl  (cl_now),
        .map_hi  (map_hi),
        .map_lo  (map_lo)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = grp_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = grp_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cl_q    <= '0;
            swp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (grp_valid) begin
                cl_q  <= cl_now;
                swp_q <= swp_now;
            end
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_cluster = '0;
        out_swap    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EMIT: begin
                out_valid   = 1'b1;
                out_cluster = cl_q;
                out_swap    = swp_q;
            end
            default: ;
        endcase
    end

    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(grp_valid)); // R2

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_cluster == '0 && out_swap == '0)); // R2

    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
        AST_SWAP_NEEDS_COMM: assert property (@(posedge clk) disable iff (!rst_n)
            out_swap[g] |-> ($past(comm[g]) && $past(nops[2*g+1]) && $past(rnd[2*g]))); // R6

        AST_DEAD_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !$past(slot_valid[g])) |->
            (out_cluster[2*g +: 2] == 2'b00 && !out_swap[g])); // R9
    end

endmodule

// File: tb/tb_steer_unit.sv
module tb_steer_unit;

    localparam int NLREG = 32;
    localparam int NSLOT = 4;
    localparam int LW    = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 grp_valid = 1'b0;
    logic [NSLOT-1:0]     slot_valid = '0;
    logic [NSLOT*LW-1:0]  src1 = '0;
    logic [NSLOT*LW-1:0]  src2 = '0;
    logic [NSLOT*LW-1:0]  dst = '0;
    logic [NSLOT-1:0]     dst_en = '0;
    logic [2*NSLOT-1:0]   nops = '0;
    logic [NSLOT-1:0]     comm = '0;
    logic [2*NSLOT-1:0]   rnd = '0;
    logic                 out_valid;
    logic [2*NSLOT-1:0]   out_cluster;
    logic [NSLOT-1:0]     out_swap;

    int checks = 0;
    int errors = 0;

    logic          s_v  [NSLOT];
    logic [LW-1:0] s_a  [NSLOT];
    logic [LW-1:0] s_b  [NSLOT];
    logic [LW-1:0] s_d  [NSLOT];
    logic          s_de [NSLOT];
    logic [1:0]    s_n  [NSLOT];
    logic          s_c  [NSLOT];
    logic [1:0]    s_r  [NSLOT];

    logic m_hi [NLREG];
    logic m_lo [NLREG];

    logic [2*NSLOT-1:0] q_cl  [$];
    logic [NSLOT-1:0]   q_sw  [$];
    string              q_tag [$];

    steer_unit #(.NLREG(NLREG), .NSLOT(NSLOT)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .grp_valid   (grp_valid),
        .slot_valid  (slot_valid),
        .src1        (src1),
        .src2        (src2),
        .dst         (dst),
        .dst_en      (dst_en),
        .nops        (nops),
        .comm        (comm),
        .rnd         (rnd),
        .out_valid   (out_valid),
        .out_cluster (out_cluster),
        .out_swap    (out_swap)
    );

    always #2 clk = ~clk;

    task automatic clr();
        for (int i = 0; i < NSLOT; i++) begin
            s_v[i] = 0; s_a[i] = '0; s_b[i] = '0; s_d[i] = '0;
            s_de[i] = 0; s_n[i] = '0; s_c[i] = 0; s_r[i] = '0;
        end
    endtask

    task automatic put(int i, int a, int b, int d, bit de, int n, bit c, int r);
        s_v[i] = 1; s_a[i] = LW'(a); s_b[i] = LW'(b); s_d[i] = LW'(d);
        s_de[i] = de; s_n[i] = 2'(n); s_c[i] = c; s_r[i] = 2'(r);
    endtask

    task automatic apply_ports(bit acc);
        for (int i = 0; i < NSLOT; i++) begin
            slot_valid[i]       = s_v[i];
            src1[i*LW +: LW]    = s_a[i];
            src2[i*LW +: LW]    = s_b[i];
            dst[i*LW +: LW]     = s_d[i];
            dst_en[i]           = s_de[i];
            nops[2*i +: 2]      = s_n[i];
            comm[i]             = s_c[i];
            rnd[2*i +: 2]       = s_r[i];
        end
        grp_valid = acc;
    endtask

    // Driver: compute the expectation from the requirements, queue it, drive.
    task automatic send(string tag);
        logic [1:0] cl [NSLOT];
        logic       sw [NSLOT];
        logic [1:0] la, lb;
        logic [2*NSLOT-1:0] pc;
        logic [NSLOT-1:0]   ps;
        for (int i = 0; i < NSLOT; i++) begin
            cl[i] = 2'b00; sw[i] = 1'b0;
            if (s_v[i]) begin
                la = {m_hi[s_a[i]], m_lo[s_a[i]]};
                lb = {m_hi[s_b[i]], m_lo[s_b[i]]};
                for (int j = 0; j < i; j++) begin
                    if (s_v[j] && s_de[j] && s_d[j] == s_a[i]) la = cl[j];
                    if (s_v[j] && s_de[j] && s_d[j] == s_b[i]) lb = cl[j];
                end
                if (s_n[i] == 2'd0) cl[i] = s_r[i];
                else if (s_n[i] == 2'd1) cl[i] = {la[1], s_r[i][0]};
                else if (s_c[i] && la != lb && s_r[i][0]) begin
                    cl[i] = {lb[1], la[0]}; sw[i] = 1'b1;
                end else cl[i] = {la[1], lb[0]};
            end
        end
        for (int i = 0; i < NSLOT; i++) begin
            pc[2*i +: 2] = cl[i];
            ps[i] = sw[i];
            if (s_v[i] && s_de[i]) begin
                m_hi[s_d[i]] = cl[i][1];
                m_lo[s_d[i]] = cl[i][0];
            end
        end
        @(negedge clk);
        q_cl.push_back(pc);
        q_sw.push_back(ps);
        q_tag.push_back(tag);
        apply_ports(1'b1);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            grp_valid = 1'b0;
        end
    endtask

    // Monitor: compare each presented result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (q_cl.size() == 0) begin
                errors++;
                $display("FAIL R2: out_valid without accepted group, actual=1 expected=0");
            end else begin
                logic [2*NSLOT-1:0] ec;
                logic [NSLOT-1:0]   es;
                string              tg;
                ec = q_cl.pop_front();
                es = q_sw.pop_front();
                tg = q_tag.pop_front();
                if (out_cluster !== ec || out_swap !== es) begin
                    errors++;
                    $display("FAIL %s: cluster=%h swap=%b expected cluster=%h swap=%b",
                             tg, out_cluster, out_swap, ec, es);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NLREG; r++) begin
            m_hi[r] = ((r % 4) >= 2);
            m_lo[r] = ((r % 2) == 1);
        end
        clr();
        apply_ports(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid=%b expected=0", out_valid);
        end
        checks++;
        if (out_cluster !== '0 || out_swap !== '0) begin
            errors++;
            $display("FAIL R2: idle cluster=%h swap=%b expected 0/0", out_cluster, out_swap);
        end

        // R1 initial locations with R3 dyadic; slots 2,3 invalid (R9)
        clr();
        put(0, 2, 1, 0, 0, 2, 0, 0);     // {1,1} = 3
        put(1, 5, 6, 0, 0, 2, 0, 3);     // {0,0} = 0
        send("R1/R3/R9");
        idle(2);

        // R4 monadic and R5 no operands
        clr();
        put(0, 3, 0, 0, 0, 1, 0, 0);     // {1,0}
        put(1, 3, 0, 0, 0, 1, 0, 1);     // {1,1}
        put(2, 0, 0, 0, 0, 0, 0, 2);     // 2
        put(3, 0, 0, 0, 0, 0, 0, 1);     // 1
        send("R4/R5");
        idle(2);

        // R6 swap cases
        clr();
        put(0, 1, 2, 0, 0, 2, 1, 1);     // differ, swap -> {1,1}
        put(1, 1, 5, 0, 0, 2, 1, 1);     // same subset -> no swap
        put(2, 1, 2, 0, 0, 2, 1, 0);     // rnd0=0 -> no swap
        put(3, 1, 2, 0, 0, 3, 0, 1);     // not commutative, nops=3 as dyadic
        send("R6/R3");
        idle(2);

        // R7 forwarding chain, then R8 read back on the next edge
        clr();
        put(0, 0, 0, 7, 1, 0, 0, 2);     // cl 2, writes r7
        put(1, 7, 7, 7, 1, 2, 0, 0);     // r7 at 2 -> {1,0}=2, writes r7
        put(2, 7, 0, 9, 1, 1, 0, 1);     // {1,1}=3, writes r9
        put(3, 9, 9, 4, 1, 2, 0, 0);     // r9 at 3 -> 3
        send("R7");
        clr();
        put(0, 7, 9, 0, 0, 2, 0, 0);     // {1,1}=3 via map update
        put(1, 9, 7, 0, 0, 2, 0, 0);     // {1,0}=2
        put(2, 4, 4, 0, 0, 2, 0, 0);     // r4 at 3
        send("R8");
        idle(2);

        // R7 youngest older writer wins
        clr();
        put(0, 0, 0, 12, 1, 0, 0, 1);    // r12 -> 1
        put(1, 0, 0, 12, 1, 0, 0, 2);    // r12 -> 2
        put(2, 12, 12, 0, 0, 2, 0, 0);   // {1,0}=2
        send("R7");
        idle(2);

        // R9 invalid slot neither forwards nor updates
        clr();
        put(0, 0, 0, 20, 1, 0, 0, 3);
        s_v[0] = 0;                      // invalid writer of r20 (home subset 0)
        put(1, 20, 20, 0, 0, 2, 0, 0);   // r20 stays 0 -> 0
        send("R9");
        clr();
        put(0, 20, 20, 0, 0, 2, 0, 0);
        send("R9");
        idle(2);

        // R10 inputs without grp_valid change nothing
        clr();
        put(0, 0, 0, 22, 1, 0, 0, 1);    // r22 home subset 2
        @(negedge clk);
        apply_ports(1'b0);
        idle(2);
        clr();
        put(0, 22, 22, 0, 0, 2, 0, 0);   // {1,0}=2
        send("R10");
        idle(2);

        // Randomized back-to-back groups over few registers
        for (int g = 0; g < 400; g++) begin
            clr();
            for (int i = 0; i < NSLOT; i++) begin
                put(i, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                    1'($urandom), $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3));
                if ($urandom_range(0, 5) == 0) s_v[i] = 0;
            end
            send("R3/R6/R7/R8 random");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(3);

        checks++;
        if (q_cl.size() != 0) begin
            errors++;
            $display("FAIL R2: pending results actual=%0d expected=0", q_cl.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule